// File: doc/BRIEF.md
# Multithreaded Instruction Fetch Sequencer

This block picks one of four hardware threads each time its output stage is free and turns that thread's 64-byte instruction-cache block into a fetch group. A group has eight slots. Each slot is an eight-byte fetch unit. A per-slot valid mask marks which slots hold real work. The mask leaves out slots that come before the thread's entry point inside the block. It also leaves out every slot after the first predicted-taken branch. Alongside the group the block reports the thread number and the address that thread should fetch from next.

Threads are served in a fixed circular order, and threads that are not ready are skipped. The search for the next thread always begins one past the thread that was served last. A combinational request (`fetch_req_o`, `fetch_tid_o`, `fetch_blk_o`) names the thread and the block address being fetched in the current cycle. The cache, the predictor and the program counters answer on the block, branch and PC inputs in the same cycle. The resulting group is held in an output register until the downstream stage takes it.

Top module: `fetch_seq_top`

## Requirements
- R1: After a group from thread t is captured, the next capture serves the first valid thread in the order t+1, t+2, t+3, t, wrapping modulo 4. After reset the search starts at thread 0. `grp_tid_o` reports the served thread.
- R2: Threads whose `thr_vld_i` bit is low are never served. When no thread is valid and the output stage is free, `grp_vld_o` is low after the next clock edge.
- R3: Slot i of `grp_insn_o` (bits [64i+63:64i]) equals bits [64i+63:64i] of `blk_data_i` in the capture cycle.
- R4: The first valid slot is the value of PC bits [5:3]. Every slot below it has mask bit 0. PC bits [2:0] have no effect.
- R5: With no predicted-taken bit set on any slot at or after the start slot, every slot from the start slot to slot 7 is valid. `grp_next_pc_o` is then the next 64-byte boundary above the PC. With start slot 0 this gives all eight slots.
- R6: With a predicted-taken bit on valid slot k, and none on the valid slots before k, slots up to and including k are valid. Slots above k are invalid, and `grp_next_pc_o` equals the target of slot k. Taken bits on slots below the start slot are ignored.
- R7: While `grp_vld_o` is high and `out_ready_i` is low, every group output holds its value and the rotation pointer does not move, whatever the other inputs do.
- R8: Synchronous active-high reset clears `grp_vld_o`, `grp_mask_o`, `grp_tid_o`, `grp_insn_o` and `grp_next_pc_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_vld_i | input | 4 | Per-thread ready-to-fetch flags |
| thr_pc_i | input | 4x48 | Per-thread fetch address |
| fetch_req_o | output | 1 | A thread is being fetched this cycle |
| fetch_tid_o | output | 2 | Thread being fetched this cycle |
| fetch_blk_o | output | 48 | 64-byte aligned address of the block being fetched |
| blk_data_i | input | 512 | Cache block for the requested address |
| pred_taken_i | input | 8 | Per-slot predicted-taken flags |
| pred_tgt_i | input | 8x48 | Per-slot predicted targets |
| out_ready_i | input | 1 | Downstream accepts the current group |
| grp_vld_o | output | 1 | Output group is valid |
| grp_tid_o | output | 2 | Thread of the output group |
| grp_mask_o | output | 8 | Per-slot valid mask |
| grp_insn_o | output | 512 | Eight 64-bit slots of the group |
| grp_next_pc_o | output | 48 | Next fetch address for that thread |

## Verification
Every group result (thread, mask, slots, next address) is due one clock edge after the cycle in which its inputs are presented, provided the output stage is free. A stall must leave the outputs unchanged at every later edge until ready returns. The bench drives each stimulus one time unit after a rising edge and samples one time unit after the following edge, so it always reads the register that the edge in question loaded. It keeps its own model of the rotation pointer and moves it only on cycles in which it expects a capture. For that reason a stall or an idle cycle must leave the next served thread unchanged.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;
  localparam int NUM_THR   = 4;
  localparam int SLOTS     = 8;
  localparam int SLOT_W    = 64;
  localparam int PC_W      = 48;
  localparam int TID_W     = $clog2(NUM_THR);
  localparam int OFF_LSB   = $clog2(SLOT_W / 8);
  localparam int OFF_W     = $clog2(SLOTS);
  localparam int BLK_LSB   = OFF_LSB + OFF_W;
  localparam int BLK_W     = SLOTS * SLOT_W;

  typedef logic [PC_W-1:0]  pc_t;
  typedef logic [TID_W-1:0] tid_t;
  typedef logic [SLOTS-1:0] mask_t;
endpackage

// File: rtl/fetch_rr_pick.sv
module fetch_rr_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic          any_o,
  output logic [IW-1:0] sel_o
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    any_o = 1'b0;
    sel_o = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (!any_o && req_i[idx]) begin
        any_o = 1'b1;
        sel_o = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (adv_i && any_o) begin
      ptr_q <= (int'(sel_o) == N - 1) ? '0 : sel_o + 1'b1;
    end
  end

  AST_PICK_REQUESTER: assert property (@(posedge clk) disable iff (rst)
    any_o |-> req_i[sel_o]);                                   // R2
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(ptr_q));                                 // R7
  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (rst)
    (req_i == '0) |-> !any_o);                                  // R2
endmodule

// File: rtl/fetch_group_form.sv
module fetch_group_form
  import fetch_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  pc_t                  pc_i,
  input  mask_t                taken_i,
  input  logic [SLOTS-1:0][PC_W-1:0] tgt_i,
  output mask_t                mask_o,
  output pc_t                  next_pc_o
);
  logic [OFF_W-1:0] start;
  pc_t              seq_pc;
  mask_t            lead;

  assign start  = pc_i[BLK_LSB-1:OFF_LSB];
  assign seq_pc = {pc_i[PC_W-1:BLK_LSB] + 1'b1, {BLK_LSB{1'b0}}};

  always_comb begin
    logic stop;
    stop      = 1'b0;
    mask_o    = '0;
    next_pc_o = seq_pc;
    for (int i = 0; i < SLOTS; i++) begin
      if (!stop && (i >= int'(start))) begin
        mask_o[i] = 1'b1;
        if (taken_i[i]) begin
          stop      = 1'b1;
          next_pc_o = tgt_i[i];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) lead[i] = (i < int'(start));
  end

  AST_FULL_GROUP: assert property (@(posedge clk) disable iff (rst)
    (start == '0 && taken_i == '0) |-> (mask_o == '1));         // R5
  AST_LEAD_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (mask_o & lead) == '0);                                     // R4
  AST_START_SLOT: assert property (@(posedge clk) disable iff (rst)
    mask_o[start]);                                             // R4
endmodule

// File: rtl/fetch_seq_top.sv
module fetch_seq_top
  import fetch_seq_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_THR-1:0]           thr_vld_i,
  input  logic [NUM_THR-1:0][PC_W-1:0] thr_pc_i,
  output logic                         fetch_req_o,
  output logic [TID_W-1:0]             fetch_tid_o,
  output logic [PC_W-1:0]              fetch_blk_o,
  input  logic [BLK_W-1:0]             blk_data_i,
  input  logic [SLOTS-1:0]             pred_taken_i,
  input  logic [SLOTS-1:0][PC_W-1:0]   pred_tgt_i,
  input  logic                         out_ready_i,
  output logic                         grp_vld_o,
  output logic [TID_W-1:0]             grp_tid_o,
  output logic [SLOTS-1:0]             grp_mask_o,
  output logic [BLK_W-1:0]             grp_insn_o,
  output logic [PC_W-1:0]              grp_next_pc_o
);
  logic  slot_free;
  logic  any_vld;
  tid_t  sel_tid;
  pc_t   sel_pc;
  mask_t new_mask;
  pc_t   new_next;

  assign slot_free = !grp_vld_o || out_ready_i;

  fetch_rr_pick #(.N(NUM_THR)) u_pick (
    .clk   (clk),
    .rst   (rst),
    .req_i (thr_vld_i),
    .adv_i (slot_free),
    .any_o (any_vld),
    .sel_o (sel_tid)
  );

  assign sel_pc      = thr_pc_i[sel_tid];
  assign fetch_req_o = any_vld && slot_free;
  assign fetch_tid_o = sel_tid;
  assign fetch_blk_o = {sel_pc[PC_W-1:BLK_LSB], {BLK_LSB{1'b0}}};

  fetch_group_form u_form (
    .clk       (clk),
    .rst       (rst),
    .pc_i      (sel_pc),
    .taken_i   (pred_taken_i),
    .tgt_i     (pred_tgt_i),
    .mask_o    (new_mask),
    .next_pc_o (new_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_vld_o     <= 1'b0;
      grp_tid_o     <= '0;
      grp_mask_o    <= '0;
      grp_insn_o    <= '0;
      grp_next_pc_o <= '0;
    end else if (slot_free) begin
      grp_vld_o <= any_vld;
      if (any_vld) begin
        grp_tid_o     <= sel_tid;
        grp_mask_o    <= new_mask;
        grp_insn_o    <= blk_data_i;
        grp_next_pc_o <= new_next;
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (grp_vld_o && !out_ready_i) |=> (grp_vld_o && $stable(grp_tid_o) && $stable(grp_mask_o)
      && $stable(grp_insn_o) && $stable(grp_next_pc_o)));       // R7
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (slot_free && thr_vld_i == '0) |=> !grp_vld_o);            // R2
  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (rst)
    grp_vld_o |-> (grp_mask_o != '0));                          // R4
endmodule

// File: tb/tb_fetch_seq_top.sv
module tb_fetch_seq_top;
  import fetch_seq_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_THR-1:0]           thr_vld_i = '0;
  logic [NUM_THR-1:0][PC_W-1:0] thr_pc_i = '0;
  logic                         fetch_req_o;
  logic [TID_W-1:0]             fetch_tid_o;
  logic [PC_W-1:0]              fetch_blk_o;
  logic [BLK_W-1:0]             blk_data_i = '0;
  logic [SLOTS-1:0]             pred_taken_i = '0;
  logic [SLOTS-1:0][PC_W-1:0]   pred_tgt_i = '0;
  logic                         out_ready_i = 1'b1;
  logic                         grp_vld_o;
  logic [TID_W-1:0]             grp_tid_o;
  logic [SLOTS-1:0]             grp_mask_o;
  logic [BLK_W-1:0]             grp_insn_o;
  logic [PC_W-1:0]              grp_next_pc_o;

  int checks = 0;
  int errors = 0;
  int mptr   = 0;
  bit done   = 0;

  logic             e_vld;
  logic [1:0]       e_tid;
  logic [7:0]       e_mask;
  logic [PC_W-1:0]  e_next;
  logic [BLK_W-1:0] e_insn;

  always #2.5 clk = ~clk;

  fetch_seq_top dut (.*);

  // fields: valid[14:11], start slot[10:8], taken[7:0]
  localparam int NV = 12;
  localparam logic [14:0] VEC [NV] = '{
    {4'hF, 3'd0, 8'h00}, {4'hF, 3'd0, 8'h08}, {4'hF, 3'd2, 8'h00},
    {4'hF, 3'd5, 8'h01}, {4'hF, 3'd4, 8'h30}, {4'h5, 3'd0, 8'h80},
    {4'hA, 3'd7, 8'h80}, {4'h2, 3'd1, 8'h02}, {4'h0, 3'd0, 8'h00},
    {4'h9, 3'd3, 8'hFF}, {4'h8, 3'd6, 8'h00}, {4'hF, 3'd0, 8'h01}
  };

  task automatic chk(string req, string what, logic [BLK_W-1:0] got, logic [BLK_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic drive(logic [3:0] vld, logic [2:0] off, logic [7:0] tk, int tag, bit rdy);
    thr_vld_i    = vld;
    out_ready_i  = rdy;
    pred_taken_i = tk;
    for (int t = 0; t < NUM_THR; t++)
      thr_pc_i[t] = (PC_W'(t) << 20) | (PC_W'(tag) << 6) | (PC_W'(off) << 3) | PC_W'(3'b101);
    for (int i = 0; i < SLOTS; i++) begin
      blk_data_i[i*SLOT_W +: SLOT_W] = {16'hA5C3, 16'(tag), 32'(i)};
      pred_tgt_i[i] = 48'h7000_0000 + PC_W'(i) * 48'h40 + PC_W'(tag) * 48'h1000;
    end
  endtask

  // Reference model of one capture from the currently driven inputs.
  task automatic predict();
    int sel;
    logic [PC_W-1:0] pc;
    int st;
    bit stop;
    sel = -1;
    for (int k = 0; k < NUM_THR; k++)
      if (sel < 0 && thr_vld_i[(mptr + k) % NUM_THR]) sel = (mptr + k) % NUM_THR;
    e_vld = (sel >= 0);
    if (sel < 0) return;
    e_tid  = 2'(sel);
    mptr   = (sel + 1) % NUM_THR;
    pc     = thr_pc_i[sel];
    st     = int'(pc[5:3]);
    e_next = {pc[PC_W-1:6] + 1'b1, 6'd0};
    e_mask = '0;
    stop   = 0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!stop && i >= st) begin
        e_mask[i] = 1'b1;
        if (pred_taken_i[i]) begin stop = 1; e_next = pred_tgt_i[i]; end
      end
    end
    e_insn = blk_data_i;
  endtask

  task automatic check_group(string req);
    chk(req, "grp_vld_o", BLK_W'(grp_vld_o), BLK_W'(e_vld));
    if (e_vld) begin
      chk("R1", "grp_tid_o", BLK_W'(grp_tid_o), BLK_W'(e_tid));
      chk(req, "grp_mask_o", BLK_W'(grp_mask_o), BLK_W'(e_mask));
      chk(req, "grp_next_pc_o", BLK_W'(grp_next_pc_o), BLK_W'(e_next));
      chk("R3", "grp_insn_o", grp_insn_o, e_insn);
    end
  endtask

  task automatic step_expect(logic [3:0] vld, logic [2:0] off, logic [7:0] tk, int tag, string req);
    drive(vld, off, tk, tag, 1'b1);
    predict();
    @(posedge clk); #1;
    check_group(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [TID_W-1:0] h_tid;
    logic [7:0]       h_mask;
    logic [PC_W-1:0]  h_next;
    logic [BLK_W-1:0] h_insn;

    // R8: reset state
    drive(4'hF, 3'd3, 8'h10, 7, 1'b1);
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "grp_vld_o", BLK_W'(grp_vld_o), '0);
    chk("R8", "grp_mask_o", BLK_W'(grp_mask_o), '0);
    chk("R8", "grp_tid_o", BLK_W'(grp_tid_o), '0);
    chk("R8", "grp_next_pc_o", BLK_W'(grp_next_pc_o), '0);
    chk("R8", "grp_insn_o", grp_insn_o, '0);
    rst = 1'b0;
    mptr = 0;

    // Table walk: R1 rotation, R2 skip/idle, R4 start, R5 sequential, R6 taken
    for (int v = 0; v < NV; v++) begin
      string req;
      req = (VEC[v][7:0] == 8'h00) ? "R5" : "R6";
      if (VEC[v][14:11] == 4'h0) req = "R2";
      step_expect(VEC[v][14:11], VEC[v][10:8], VEC[v][7:0], v + 1, req);
    end

    // R7: stall holds outputs and pointer
    step_expect(4'hF, 3'd1, 8'h04, 40, "R6");
    h_tid = grp_tid_o; h_mask = grp_mask_o; h_next = grp_next_pc_o; h_insn = grp_insn_o;
    drive(4'hF, 3'd0, 8'h00, 41, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    chk("R7", "grp_vld_o held", BLK_W'(grp_vld_o), BLK_W'(1'b1));
    chk("R7", "grp_tid_o held", BLK_W'(grp_tid_o), BLK_W'(h_tid));
    chk("R7", "grp_mask_o held", BLK_W'(grp_mask_o), BLK_W'(h_mask));
    chk("R7", "grp_next_pc_o held", BLK_W'(grp_next_pc_o), BLK_W'(h_next));
    chk("R7", "grp_insn_o held", grp_insn_o, h_insn);
    // pointer unmoved: next capture follows the held thread
    step_expect(4'hF, 3'd0, 8'h00, 42, "R7");

    // R4: pc low bits have no effect (drive already sets them), high start slot
    step_expect(4'h4, 3'd7, 8'h00, 43, "R4");
    // R6: taken before start slot ignored
    step_expect(4'h1, 3'd6, 8'h3F, 44, "R6");

    // R2: idle then recovery keeps the pointer
    step_expect(4'h0, 3'd0, 8'h00, 45, "R2");
    step_expect(4'hF, 3'd0, 8'h00, 46, "R1");

    // R1: after reset the search restarts at thread 0
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    mptr = 0;
    step_expect(4'hF, 3'd0, 8'h00, 47, "R1");
    step_expect(4'hF, 3'd0, 8'h00, 48, "R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule